// File: doc/BRIEF.md
# Channel Indicator LED Matrix Scanner

This block lights sixteen indicator LEDs for eight output channels: each channel has one status LED and one fault LED. The LEDs are wired as a 4x4 crossbar with four anode lines (status for the low four channels, status for the high four, fault for the low four, fault for the high four) and four cathode lines. Cathode line k serves the channel pair k and k+4. The scanner enables one cathode line at a time, so each anode line, and the resistor in series with it, carries current for only one LED at any instant.

A scan has four phases of equal length. Each phase begins with a short blanking interval in which every line is released, so that two cathodes never overlap. After the blanking interval, the anodes show the state of the two channels that belong to the active cathode. A channel's status LED lights when the channel is switched on and no fault is being shown. A fault LED lights while the channel's fault input is high and for a fixed stretch time after the input falls. While a fault is shown, the status LED of that channel is held off. A shutdown input, driven by chip over-temperature, releases every line at once. The scan timing keeps running during shutdown.

With the default parameters at a 200 MHz clock, one phase lasts 250 us, so each LED is refreshed at 1 kHz with a 25% duty. A fault indication is held for about 2 s.

Top module: `led_scan_matrix`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, all four cathode enables and all four anode outputs are 0. The scan then starts in phase 0.
- R2: Counting clocks n from the release of reset, the phase is (n / PHASE_CYCLES) mod 4. Outside blanking and shutdown, cath_en equals 1 << phase, so exactly one cathode bit is set. The cathode enable never has more than one bit set.
- R3: In the first BLANK_CYCLES clocks of every phase (n mod PHASE_CYCLES < BLANK_CYCLES), all cathode enables and all anodes are 0.
- R4: In phase k, stat_lo and flt_lo show channel k and stat_hi and flt_hi show channel k+4, with channels indexed from 0 at bit 0 of ch_on and ch_fault. An anode is 1 only while a cathode is enabled.
- R5: The status anode for a channel is 1 when that channel's ch_on bit is 1 and no fault is shown for it.
- R6: For the same channel group, a status anode and its fault anode are never 1 in the same cycle.
- R7: A fault is shown for a channel while its ch_fault bit is high. It stays shown for STRETCH_CYCLES clocks after the last clock edge that sampled the bit high. A new high restarts the stretch.
- R8: While led_shdn is 1, all cathode enables and anodes are 0 in that same cycle. The phase timing and the fault stretch counters keep advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_on | input | 8 | Per-channel switch-on state, bit i is channel i |
| ch_fault | input | 8 | Per-channel fault present, bit i is channel i |
| led_shdn | input | 1 | Shutdown: release all matrix lines |
| cath_en | output | 4 | Cathode line enables, one-hot or zero |
| stat_lo | output | 1 | Status anode for channels 0-3 |
| stat_hi | output | 1 | Status anode for channels 4-7 |
| flt_lo | output | 1 | Fault anode for channels 0-3 |
| flt_hi | output | 1 | Fault anode for channels 4-7 |

## Verification
The bench runs every ch_on pattern and every ch_fault pattern through a full scan. It compares every port in every cycle against a phase and stretch model computed from the clock count. A wrong pairing of channel to cathode would show up as a misplaced anode in some phase. A missing or too-short blanking interval would leave a cathode enabled at the start of a phase. Directed fault pulses check the stretch, where an off-by-one would drop the fault LED a cycle early or hold it a cycle late, and a retriggered pulse checks that the stretch restarts. Toggling shutdown in mid-scan checks that the lines go dark at once and that the scan comes back in the correct phase, not restarted.

// File: rtl/led_scan_matrix.sv
module led_scan_matrix #(
  parameter int PHASE_CYCLES   = 50000,
  parameter int BLANK_CYCLES   = 500,
  parameter int STRETCH_CYCLES = 400000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ch_on,
  input  logic [7:0] ch_fault,
  input  logic       led_shdn,
  output logic [3:0] cath_en,
  output logic       stat_lo,
  output logic       stat_hi,
  output logic       flt_lo,
  output logic       flt_hi
);
  localparam int CW = $clog2(PHASE_CYCLES);
  localparam int SW = $clog2(STRETCH_CYCLES + 1);

  logic [CW-1:0] slot;
  logic [1:0]    phase;
  logic [7:0]    flt_show;
  logic [7:0]    stat_show;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot  <= '0;
      phase <= 2'd0;
    end else if (slot == CW'(PHASE_CYCLES - 1)) begin
      slot  <= '0;
      phase <= phase + 2'd1;
    end else begin
      slot <= slot + 1'b1;
    end
  end

  for (genvar i = 0; i < 8; i++) begin : g_ch
    logic [SW-1:0] hold;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           hold <= '0;
      else if (ch_fault[i]) hold <= SW'(STRETCH_CYCLES);
      else if (hold != '0)  hold <= hold - 1'b1;
    end
    assign flt_show[i] = ch_fault[i] | (hold != '0);

    assert_fault_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ch_fault[i]) && !ch_fault[i]) |-> flt_show[i]);
  end

  assign stat_show = ch_on & ~flt_show;
  assign active    = (slot >= CW'(BLANK_CYCLES)) && !led_shdn;
  assign cath_en   = active ? (4'b0001 << phase) : 4'b0000;
  assign stat_lo   = active & stat_show[{1'b0, phase}];
  assign stat_hi   = active & stat_show[{1'b1, phase}];
  assign flt_lo    = active & flt_show[{1'b0, phase}];
  assign flt_hi    = active & flt_show[{1'b1, phase}];

  assert_cath_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cath_en));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> ($past(slot) == CW'(PHASE_CYCLES - 1)));

  assert_blank_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot < CW'(BLANK_CYCLES)) |-> (cath_en == 4'b0000 && !stat_lo && !stat_hi));

  assert_anode_needs_cath_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_lo || stat_hi || flt_lo || flt_hi) |-> (cath_en != 4'b0000));

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_lo && flt_lo) && !(stat_hi && flt_hi));

  assert_shdn_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    led_shdn |-> (cath_en == 4'b0000 && !flt_lo && !flt_hi));
endmodule

// File: tb/led_scan_matrix_bench.sv
module led_scan_matrix_bench;
  localparam int P = 5;
  localparam int B = 1;
  localparam int S = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ch_on = '0;
  logic [7:0] ch_fault = '0;
  logic       led_shdn = 1'b0;
  logic [3:0] cath_en;
  logic       stat_lo, stat_hi, flt_lo, flt_hi;

  int vectors = 0;
  int errors  = 0;
  int n = 0;
  int since [8];
  int cyc = 0;

  led_scan_matrix #(.PHASE_CYCLES(P), .BLANK_CYCLES(B), .STRETCH_CYCLES(S)) u_led_scan_matrix (
    .clk(clk), .rst_n(rst_n), .ch_on(ch_on), .ch_fault(ch_fault), .led_shdn(led_shdn),
    .cath_en(cath_en), .stat_lo(stat_lo), .stat_hi(stat_hi), .flt_lo(flt_lo), .flt_hi(flt_hi));

  always #2.5 clk = ~clk;

  initial for (int i = 0; i < 8; i++) since[i] = S;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      n = 0;
      for (int i = 0; i < 8; i++) since[i] = S;
    end else begin
      n++;
      for (int i = 0; i < 8; i++)
        if (ch_fault[i]) since[i] = 0;
        else if (since[i] < S) since[i]++;
    end
  end

  task automatic check_now();
    int ph, sl;
    logic act;
    logic [7:0] fs, ss;
    logic [3:0] e_cath;
    logic e_sl, e_sh, e_fl, e_fh;
    ph  = (n / P) % 4;
    sl  = n % P;
    act = rst_n && (sl >= B) && !led_shdn;
    for (int i = 0; i < 8; i++) fs[i] = ch_fault[i] || (since[i] < S);
    ss = ch_on & ~fs;
    e_cath = act ? (4'b0001 << ph) : 4'b0000;
    e_sl = act && ss[ph];
    e_sh = act && ss[ph + 4];
    e_fl = act && fs[ph];
    e_fh = act && fs[ph + 4];
    vectors++;
    if (cath_en !== e_cath) begin
      errors++;
      $display("FAIL %s cath_en n=%0d got %b exp %b",
               !rst_n ? "R1" : led_shdn ? "R8" : (sl < B) ? "R3" : "R2", n, cath_en, e_cath);
    end
    vectors++;
    if ({stat_lo, stat_hi} !== {e_sl, e_sh}) begin
      errors++;
      $display("FAIL R5/R4 status n=%0d on=%h flt=%h got %b%b exp %b%b",
               n, ch_on, ch_fault, stat_lo, stat_hi, e_sl, e_sh);
    end
    vectors++;
    if ({flt_lo, flt_hi} !== {e_fl, e_fh}) begin
      errors++;
      $display("FAIL R7/R4 fault n=%0d flt=%h got %b%b exp %b%b",
               n, ch_fault, flt_lo, flt_hi, e_fl, e_fh);
    end
    vectors++;
    if ((stat_lo && flt_lo) || (stat_hi && flt_hi)) begin
      errors++;
      $display("FAIL R6 exclusive n=%0d got %b%b%b%b exp no overlap",
               n, stat_lo, flt_lo, stat_hi, flt_hi);
    end
  endtask

  task automatic step(input logic [7:0] on_v, input logic [7:0] f_v, input logic sd);
    @(negedge clk);
    ch_on = on_v; ch_fault = f_v; led_shdn = sd;
    #1 check_now();
  endtask

  initial begin
    // R1: reset state with inputs active
    ch_on = 8'hFF; ch_fault = 8'hFF;
    repeat (3) begin @(negedge clk); #1 check_now(); end
    ch_fault = 8'h00;
    @(negedge clk); rst_n = 1'b1; #1 check_now();
    repeat (S + 2) step(8'h00, 8'h00, 1'b0);
    // R2 R4 R5: all switch-on patterns, one full scan each
    for (int v = 0; v < 256; v++)
      repeat (4 * P) step(8'(v), 8'h00, 1'b0);
    // R6 R7: all fault patterns with changing on patterns
    for (int v = 0; v < 256; v++)
      repeat (4 * P) step(8'(v * 37 + 11), 8'(v), 1'b0);
    repeat (S + 4 * P) step(8'hFF, 8'h00, 1'b0);
    // R7: single pulses of varying length and retrigger
    for (int c = 0; c < 8; c++) begin
      repeat (c + 1) step(8'hFF, 8'(1 << c), 1'b0);
      repeat (S / 2) step(8'hFF, 8'h00, 1'b0);
      step(8'hFF, 8'(1 << c), 1'b0);
      repeat (S + 3 * P) step(8'hFF, 8'h00, 1'b0);
    end
    // R8: shutdown toggled mid-scan, scan position preserved
    for (int k = 0; k < 300; k++)
      step(8'h5A, (k % 50 < 3) ? 8'h81 : 8'h00, ((k / 7) % 3) == 1);
    repeat (4 * P) step(8'hC3, 8'h00, 1'b0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog got %0d cycles exp completion", cyc);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule